// File: doc/BRIEF.md
# Flash Write-Status Read Generator

This block forms the byte a host sees when it reads a flash device while a program or erase is running inside the device. The command decoder raises a busy level once the final write of a command has been accepted: the fourth write for a byte program, the sixth for any erase. Along with busy, the decoder supplies the operation type and the byte being programmed. Each host read arrives as a one-cycle strobe. While busy is high, the block answers with a polling bit in the top bit and an alternating bit just below it. Both follow fixed rules, so host software can tell when the operation has finished.

When busy falls, the block does not hand the read path straight back to the array. For a settle window of `SETTLE`+1 cycles, counted from the first cycle busy is low, it returns the array's top bit, the frozen toggle bit, and zeros in the lower bits. This models a device in which the polling bit becomes valid before the rest of the byte. After the window, reads return the array byte unchanged. The result of each read is registered and holds until the next strobe.

Top module: `flash_status_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `rd_data` is all zeros.
- R2: On a read while a program is busy, bit DW-1 of `rd_data` is the complement of bit DW-1 of the byte being programmed.
- R3: On a read while an erase is busy (`op_erase`=1 when busy rose), bit DW-1 of `rd_data` is 0.
- R4: On a read while busy, bits DW-3..0 of `rd_data` are 0.
- R5: The toggle state is preset to `TOG_INIT` on the cycle busy rises, including when busy rises during a settle window. The first busy read of each operation therefore returns bit DW-2 equal to the inverse of `TOG_INIT` (1 with the default).
- R6: Each later read while busy returns bit DW-2 inverted from the previous busy read.
- R7: Once busy is low, bit DW-2 stops alternating: every read in the settle window returns the value of the last busy read.
- R8: In the settle window, a read returns the array's bit DW-1 in bit DW-1, the frozen toggle in bit DW-2, and zeros below. The window covers the first SETTLE+1 cycles with busy low.
- R9: After the settle window, and when idle, a read returns `array_data` unchanged.
- R10: Without a read strobe, `rd_data` keeps its value.
- R11: The operation type and the programmed byte are captured on the cycle busy rises. Changes to them while busy have no effect on later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Internal program/erase in progress, from the command decoder |
| op_erase | input | 1 | Operation type sampled when busy rises: 1 = erase, 0 = program |
| prog_data | input | DW | Byte being programmed, sampled when busy rises |
| array_data | input | DW | Byte read from the array at the current address |
| rd_stb | input | 1 | One-cycle host read strobe |
| rd_data | output | DW | Registered read result |

## Verification
The hardest situation to reach is a new operation starting inside the settle window of the previous one. In that case the toggle carries a stale value and must be preset, not flipped. The stimulus ends an erase so that its last busy read leaves the toggle at 1, then raises busy again one cycle later, with a read strobe on the very cycle busy rises. The settle window boundary is also probed with reads on the last settle cycle and the first array cycle.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int DW       = 8,
  parameter int SETTLE   = 50,
  parameter bit TOG_INIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          op_erase,
  input  logic [DW-1:0] prog_data,
  input  logic [DW-1:0] array_data,
  input  logic          rd_stb,
  output logic [DW-1:0] rd_data
);
  localparam int CW = $clog2(SETTLE + 1);

  logic          busy_q, era_q, pd_q, tog;
  logic [CW-1:0] cnt;
  logic [DW-1:0] nxt;

  wire start    = busy & ~busy_q;
  wire fall     = ~busy & busy_q;
  wire era_e    = start ? op_erase : era_q;
  wire pd_e     = start ? prog_data[DW-1] : pd_q;
  wire tog_b    = start ? TOG_INIT : tog;
  wire settling = fall | (cnt != '0);

  always_comb begin
    if (busy)          nxt = {~era_e & ~pd_e, ~tog_b, {(DW-2){1'b0}}};
    else if (settling) nxt = {array_data[DW-1], tog, {(DW-2){1'b0}}};
    else               nxt = array_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      era_q   <= 1'b0;
      pd_q    <= 1'b0;
      tog     <= TOG_INIT;
      cnt     <= '0;
      rd_data <= '0;
    end else begin
      busy_q <= busy;
      if (start) begin
        era_q <= op_erase;
        pd_q  <= prog_data[DW-1];
      end
      if (busy && rd_stb) tog <= ~tog_b;
      else if (start)     tog <= TOG_INIT;
      if (busy)              cnt <= '0;
      else if (fall)         cnt <= CW'(SETTLE);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
      if (rd_stb) rd_data <= nxt;
    end
  end
endmodule

module flash_status_gen_chk #(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rd_stb,
  input logic [DW-1:0] array_data,
  input logic [DW-1:0] rd_data,
  input logic          busy_q,
  input logic          tog,
  input logic [CW-1:0] cnt
);
  p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy) |=> rd_data[DW-3:0] == '0);
  p_tog_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy) |=> rd_data[DW-2] == tog);
  p_tog_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && busy_q) |=> tog != $past(tog));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> tog == $past(tog));
  p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy && (busy_q || cnt != '0)) |=>
      (rd_data[DW-1] == $past(array_data[DW-1])) && (rd_data[DW-3:0] == '0));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy && !busy_q && cnt == '0) |=> rd_data == $past(array_data));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

bind flash_status_gen flash_status_gen_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_stb(rd_stb),
  .array_data(array_data), .rd_data(rd_data),
  .busy_q(busy_q), .tog(tog), .cnt(cnt)
);

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int SETTLE = 4;
  localparam int NV = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busy = 1'b0, op_erase = 1'b0, rd_stb = 1'b0;
  logic [DW-1:0] prog_data = '0, array_data = '0;
  logic [DW-1:0] rd_data;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.DW(DW), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
    .prog_data(prog_data), .array_data(array_data),
    .rd_stb(rd_stb), .rd_data(rd_data)
  );

  // [31] busy [30] erase [29:22] prog [21:14] array [13] rd [12] chk [11:4] expected [3:0] req
  localparam logic [31:0] VEC [NV] = '{
    {1'b1,1'b0,8'h35,8'h00,1'b1,1'b1,8'hC0,4'd2},  // R2 R5 program start read
    {1'b1,1'b0,8'hFF,8'h00,1'b1,1'b1,8'h80,4'd11}, // R11 R6 prog byte change ignored
    {1'b1,1'b0,8'hFF,8'h00,1'b0,1'b1,8'h80,4'd10}, // R10 hold
    {1'b1,1'b0,8'hFF,8'h00,1'b1,1'b1,8'hC0,4'd6},  // R6
    {1'b0,1'b0,8'hFF,8'h35,1'b1,1'b1,8'h40,4'd8},  // R8 R7 first low cycle
    {1'b0,1'b0,8'hFF,8'h35,1'b1,1'b1,8'h40,4'd7},  // R7
    {1'b0,1'b0,8'hFF,8'h35,1'b0,1'b1,8'h40,4'd10}, // R10
    {1'b0,1'b0,8'hFF,8'h35,1'b1,1'b1,8'h40,4'd8},  // R8
    {1'b0,1'b0,8'hFF,8'h35,1'b1,1'b1,8'h40,4'd8},  // R8 last settle cycle
    {1'b0,1'b0,8'hFF,8'h35,1'b1,1'b1,8'h35,4'd9},  // R9 first array cycle
    {1'b0,1'b0,8'hFF,8'hA7,1'b1,1'b1,8'hA7,4'd9},  // R9
    {1'b1,1'b1,8'hFF,8'hA7,1'b1,1'b1,8'h40,4'd3},  // R3 R5 erase start
    {1'b1,1'b0,8'hFF,8'hA7,1'b1,1'b1,8'h00,4'd11}, // R11 type change ignored
    {1'b1,1'b0,8'hFF,8'hA7,1'b1,1'b1,8'h40,4'd6},  // R6
    {1'b1,1'b0,8'hFF,8'hA7,1'b1,1'b1,8'h00,4'd6},  // R6 R4
    {1'b0,1'b0,8'hFF,8'hFF,1'b1,1'b1,8'h80,4'd8},  // R8 erased reads 1
    {1'b0,1'b0,8'hFF,8'hFF,1'b1,1'b1,8'h80,4'd7},  // R7
    {1'b0,1'b0,8'hFF,8'hFF,1'b1,1'b1,8'h80,4'd7},  // R7
    {1'b0,1'b0,8'hFF,8'hFF,1'b1,1'b1,8'h80,4'd8},  // R8
    {1'b0,1'b0,8'hFF,8'hFF,1'b1,1'b1,8'h80,4'd8},  // R8
    {1'b0,1'b0,8'hFF,8'hFF,1'b1,1'b1,8'hFF,4'd9},  // R9
    {1'b1,1'b0,8'h80,8'h11,1'b0,1'b0,8'h00,4'd0},  // program start, no read
    {1'b1,1'b0,8'h80,8'h11,1'b1,1'b1,8'h40,4'd2},  // R2 R5
    {1'b0,1'b0,8'h80,8'h11,1'b0,1'b0,8'h00,4'd0},
    {1'b0,1'b0,8'h80,8'h11,1'b1,1'b1,8'h40,4'd8},  // R8
    {1'b0,1'b0,8'h80,8'h11,1'b0,1'b1,8'h40,4'd10}, // R10
    {1'b0,1'b0,8'h80,8'h11,1'b0,1'b1,8'h40,4'd10}, // R10
    {1'b0,1'b0,8'h80,8'h11,1'b1,1'b1,8'h40,4'd8},  // R8 boundary
    {1'b0,1'b0,8'h80,8'h11,1'b1,1'b1,8'h11,4'd9},  // R9 boundary
    {1'b1,1'b1,8'h00,8'h00,1'b1,1'b1,8'h40,4'd3},  // R3 toggle left at 1
    {1'b0,1'b0,8'h00,8'h00,1'b1,1'b1,8'h40,4'd7},  // R7 settle
    {1'b1,1'b0,8'h00,8'h00,1'b1,1'b1,8'hC0,4'd5}   // R5 preset inside settle window
  };

  task automatic check(input logic [DW-1:0] exp, input int req);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL R%0d: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check('0, 1);            // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check('0, 1);            // R1 after release
    for (int i = 0; i < NV; i++) begin
      busy       = VEC[i][31];
      op_erase   = VEC[i][30];
      prog_data  = VEC[i][29:22];
      array_data = VEC[i][21:14];
      rd_stb     = VEC[i][13];
      @(negedge clk);
      if (VEC[i][12]) check(VEC[i][11:4], int'(VEC[i][3:0]));
    end
    // R1: reset in the middle of a busy operation clears the output
    rd_stb = 1'b0;
    #1 rst_n = 1'b0;
    #1 check('0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    busy = 1'b1; op_erase = 1'b0; prog_data = 8'h7F; rd_stb = 1'b1;
    @(negedge clk);
    check(8'hC0, 5);         // R5 R2 first read after reset with busy high
    busy = 1'b0; array_data = 8'h5A; rd_stb = 1'b0;
    repeat (SETTLE + 1) @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    check(8'h5A, 9);         // R9 after full window with no reads
    rd_stb = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule